// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each access of a short burst in a synchronous memory. A controller presents a starting address once. After that, each cycle that requests an advance steps the two lowest address bits to the next beat. The upper address bits do not change until the next load. Two beat orders are available: one counts upward and wraps, and the other flips the low bits by XOR with the beat number. The order is chosen on the cycle that loads the address.

Along with the address, the block keeps the access kind (read or write) and a valid flag, both taken when the address is loaded. An advance does not look at the selects or at the write request on that cycle, so a burst keeps the kind it started with. A burst that began from a deselected load never becomes an access. A stall input freezes all state. The memory array and the data path belong to other blocks.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `acc_vld_o`=0, `acc_wr_o`=0, `acc_addr_o`=0 and `beat_o`=0.
- R2: A load is an edge with `stall_i`=0 and `step_i`=0. After it, `acc_addr_o` equals the `addr_i` sampled at that edge and `beat_o` is 0.
- R3: An advance is an edge with `stall_i`=0 and `step_i`=1. It adds one to `beat_o` (modulo 4) whatever `sel_i` and `wr_i` are at that edge.
- R4: If `order_i` was 0 at the load, the low two address bits after k advances are (start + k) mod 4. This is the linear order.
- R5: If `order_i` was 1 at the load, the low two address bits after k advances are start XOR (k mod 4). This is the interleaved order.
- R6: Address bits above bit 1 keep the loaded value through every advance.
- R7: After four advances the address is again the loaded start address, and the sequence repeats over the same four locations.
- R8: `acc_wr_o` takes `wr_i` at a load (1 = write, 0 = read) and keeps that value through every advance.
- R9: An edge with `stall_i`=1 changes no output, whatever the other inputs are.
- R10: `acc_vld_o` is 1 after a load only if every bit of `sel_i` was 1 at that load. Advances do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | 1 = hold all state this edge |
| step_i | input | 1 | 0 = load a new start address, 1 = advance the beat |
| sel_i | input | NSEL | Select lines. All must be 1 at a load for the burst to be valid |
| wr_i | input | 1 | Access kind at a load: 1 = write, 0 = read |
| order_i | input | 1 | Beat order at a load: 0 = linear, 1 = interleaved |
| addr_i | input | AW | Start address |
| acc_addr_o | output | AW | Address of the current beat |
| acc_wr_o | output | 1 | Access kind latched at load |
| acc_vld_o | output | 1 | Burst is a selected access |
| beat_o | output | 2 | Beats advanced since the load, modulo 4 |

## Verification
Every output comes from registers with no path from the inputs. The result of a load, an advance or a stall is therefore due exactly one cycle after the edge that samples it. The bench drives inputs on the falling edge and compares all four outputs on the next falling edge. By then one rising edge has passed, and the bench's model has been updated with the inputs that edge sampled. Stalled cycles are checked against the model's unchanged values. A full wrap therefore appears as the start address coming back on the fifth check after a load.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_INTLV  = 1'b1
    } beat_order_e;

    typedef struct packed {
        logic        valid;
        logic        is_write;
        beat_order_e order;
    } burst_attr_t;

    function automatic logic [BEAT_W-1:0] next_beat(input logic [BEAT_W-1:0] b);
        return b + BEAT_W'(1);
    endfunction

    function automatic logic [BEAT_W-1:0] linear_low(input logic [BEAT_W-1:0] start,
                                                      input logic [BEAT_W-1:0] beat);
        return start + beat;
    endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_addr_pkg::*;
#(
    parameter int AW   = 20,
    parameter int NSEL = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall_i,
    input  logic              step_i,
    input  logic [NSEL-1:0]   sel_i,
    input  logic              wr_i,
    input  logic              order_i,
    input  logic [AW-1:0]     addr_i,
    output logic [AW-1:0]     base_o,
    output logic [BEAT_W-1:0] beat_o,
    output burst_attr_t       attr_o
);

    logic do_load;
    logic do_adv;

    assign do_load = !stall_i && !step_i;
    assign do_adv  = !stall_i &&  step_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_o <= '0;
            beat_o <= '0;
            attr_o <= '{valid: 1'b0, is_write: 1'b0, order: ORD_LINEAR};
        end else if (do_load) begin
            base_o          <= addr_i;
            beat_o          <= '0;
            attr_o.valid    <= &sel_i;
            attr_o.is_write <= wr_i;
            attr_o.order    <= beat_order_e'(order_i);
        end else if (do_adv) begin
            beat_o <= next_beat(beat_o);
        end
    end

endmodule

// File: rtl/burst_map.sv
module burst_map
    import burst_addr_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic [AW-1:0]     base_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  beat_order_e       order_i,
    output logic [AW-1:0]     addr_o
);

    logic [BEAT_W-1:0] lin_bits;
    logic [BEAT_W-1:0] ilv_bits;

    assign lin_bits = linear_low(base_i[BEAT_W-1:0], beat_i);

    for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
        assign ilv_bits[i] = base_i[i] ^ beat_i[i];
    end

    always_comb begin
        addr_o = base_i;
        addr_o[BEAT_W-1:0] = (order_i == ORD_INTLV) ? ilv_bits : lin_bits;
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int AW   = 20,
    parameter int NSEL = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall_i,
    input  logic              step_i,
    input  logic [NSEL-1:0]   sel_i,
    input  logic              wr_i,
    input  logic              order_i,
    input  logic [AW-1:0]     addr_i,
    output logic [AW-1:0]     acc_addr_o,
    output logic              acc_wr_o,
    output logic              acc_vld_o,
    output logic [BEAT_W-1:0] beat_o
);

    logic [AW-1:0]     base;
    logic [BEAT_W-1:0] beat;
    burst_attr_t       attr;

    burst_ctrl #(.AW(AW), .NSEL(NSEL)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .stall_i (stall_i),
        .step_i  (step_i),
        .sel_i   (sel_i),
        .wr_i    (wr_i),
        .order_i (order_i),
        .addr_i  (addr_i),
        .base_o  (base),
        .beat_o  (beat),
        .attr_o  (attr)
    );

    burst_map #(.AW(AW)) u_map (
        .base_i  (base),
        .beat_i  (beat),
        .order_i (attr.order),
        .addr_o  (acc_addr_o)
    );

    assign acc_wr_o  = attr.is_write;
    assign acc_vld_o = attr.valid;
    assign beat_o    = beat;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int AW   = 20,
    parameter int NSEL = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            stall_i,
    input logic            step_i,
    input logic [NSEL-1:0] sel_i,
    input logic            wr_i,
    input logic [AW-1:0]   addr_i,
    input logic [AW-1:0]   acc_addr_o,
    input logic            acc_wr_o,
    input logic            acc_vld_o,
    input logic [1:0]      beat_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!acc_vld_o && !acc_wr_o && acc_addr_o == '0 && beat_o == 2'd0));

    // R2
    load_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && !step_i) |=> (acc_addr_o == $past(addr_i) && beat_o == 2'd0));

    // R3
    advance_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && step_i) |=> (beat_o == $past(beat_o) + 2'd1));

    // R6
    upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && step_i) |=> (acc_addr_o[AW-1:2] == $past(acc_addr_o[AW-1:2])));

    // R8
    kind_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && step_i) |=> (acc_wr_o == $past(acc_wr_o)));

    // R8
    kind_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && !step_i) |=> (acc_wr_o == $past(wr_i)));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> ($stable(acc_addr_o) && $stable(acc_wr_o) && $stable(acc_vld_o) && $stable(beat_o)));

    // R10
    valid_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && !step_i) |=> (acc_vld_o == $past(&sel_i)));

    // R10
    valid_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && step_i) |=> (acc_vld_o == $past(acc_vld_o)));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW), .NSEL(NSEL)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stall_i    (stall_i),
    .step_i     (step_i),
    .sel_i      (sel_i),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .acc_addr_o (acc_addr_o),
    .acc_wr_o   (acc_wr_o),
    .acc_vld_o  (acc_vld_o),
    .beat_o     (beat_o)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;

    localparam int AW   = 20;
    localparam int NSEL = 3;

    logic            clk = 1'b0;
    logic            rst;
    logic            stall_i, step_i, wr_i, order_i;
    logic [NSEL-1:0] sel_i;
    logic [AW-1:0]   addr_i;
    logic [AW-1:0]   acc_addr_o;
    logic            acc_wr_o, acc_vld_o;
    logic [1:0]      beat_o;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0] m_base;
    logic [1:0]    m_beat;
    logic          m_wr, m_vld, m_ord;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.AW(AW), .NSEL(NSEL)) dut (
        .clk(clk), .rst(rst), .stall_i(stall_i), .step_i(step_i), .sel_i(sel_i),
        .wr_i(wr_i), .order_i(order_i), .addr_i(addr_i), .acc_addr_o(acc_addr_o),
        .acc_wr_o(acc_wr_o), .acc_vld_o(acc_vld_o), .beat_o(beat_o)
    );

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] k, logic ord);
        logic [AW-1:0] a;
        a = b;
        if (ord) a[1:0] = b[1:0] ^ k;
        else     a[1:0] = b[1:0] + k;
        return a;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check({req, " addr"}, 64'(acc_addr_o), 64'(exp_addr(m_base, m_beat, m_ord)));
        check({req, " beat"}, 64'(beat_o), 64'(m_beat));
        check({req, " wr"},   64'(acc_wr_o), 64'(m_wr));
        check({req, " vld"},  64'(acc_vld_o), 64'(m_vld));
    endtask

    // drive at negedge; one posedge passes; model update; compare at next negedge
    task automatic cyc(logic st, logic sp, logic [NSEL-1:0] s, logic w, logic o,
                       logic [AW-1:0] a, string req);
        stall_i = st; step_i = sp; sel_i = s; wr_i = w; order_i = o; addr_i = a;
        @(posedge clk);
        if (!st && !sp) begin
            m_base = a; m_beat = 2'd0; m_wr = w; m_vld = &s; m_ord = o;
        end else if (!st) begin
            m_beat = m_beat + 2'd1;
        end
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        rst = 1'b1; stall_i = 0; step_i = 0; sel_i = '1; wr_i = 1; order_i = 1;
        addr_i = 20'hABCDE;
        m_base = '0; m_beat = 0; m_wr = 0; m_vld = 0; m_ord = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check_all("R1");
        rst = 1'b0;

        // R2 R4 R7 linear from start 2: 2,3,0,1,2
        cyc(0, 0, '1, 1, 0, 20'h12342, "R2");
        check("R4 b0", 64'(acc_addr_o), 64'h12342);
        cyc(0, 1, '0, 0, 1, 20'h0, "R3");
        check("R4 b1", 64'(acc_addr_o), 64'h12343);
        cyc(0, 1, '1, 0, 0, 20'hFFFFF, "R4");
        check("R4 b2", 64'(acc_addr_o), 64'h12340);
        cyc(0, 1, '1, 0, 0, 20'h0, "R4");
        check("R4 b3", 64'(acc_addr_o), 64'h12341);
        cyc(0, 1, '1, 0, 0, 20'h0, "R7");
        check("R7 wrap", 64'(acc_addr_o), 64'h12342);
        check("R8 kind kept", 64'(acc_wr_o), 64'h1);
        check("R6 upper", 64'(acc_addr_o[AW-1:2]), 64'(20'h12342 >> 2));

        // R5 interleaved from start 1: 1,0,3,2,1
        cyc(0, 0, '1, 0, 1, 20'h55551, "R5");
        check("R5 b0", 64'(acc_addr_o), 64'h55551);
        cyc(0, 1, '1, 1, 0, 20'h0, "R5");
        check("R5 b1", 64'(acc_addr_o), 64'h55550);
        // R9 stall holds despite load request
        cyc(1, 0, '1, 1, 0, 20'h00003, "R9");
        check("R9 hold", 64'(acc_addr_o), 64'h55550);
        cyc(0, 1, '1, 1, 0, 20'h0, "R5");
        check("R5 b2", 64'(acc_addr_o), 64'h55553);
        cyc(0, 1, '1, 1, 0, 20'h0, "R5");
        check("R5 b3", 64'(acc_addr_o), 64'h55552);
        check("R8 read kept", 64'(acc_wr_o), 64'h0);
        cyc(0, 1, '1, 1, 0, 20'h0, "R7");
        check("R7 ilv wrap", 64'(acc_addr_o), 64'h55551);

        // R10 deselected load stays invalid through advances
        cyc(0, 0, 3'b101, 1, 0, 20'h00010, "R10");
        check("R10 desel", 64'(acc_vld_o), 64'h0);
        cyc(0, 1, '1, 1, 0, 20'h0, "R10");
        check("R10 adv", 64'(acc_vld_o), 64'h0);

        // R1 reset mid-burst
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(negedge clk);
        m_base = '0; m_beat = 0; m_wr = 0; m_vld = 0; m_ord = 0;
        check_all("R1 again");
        rst = 1'b0;

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic st, sp;
            logic [NSEL-1:0] s;
            st = ($urandom_range(0, 9) < 2);
            sp = ($urandom_range(0, 9) < 7);
            s  = ($urandom_range(0, 9) < 8) ? '1 : NSEL'($urandom);
            cyc(st, sp, s, 1'($urandom), 1'($urandom), AW'($urandom), "R3 R9 rand");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule